// File: doc/BRIEF.md
# Load/Store-Multiple Stack Sequencer

This block expands a single block-transfer command into a run of single-word memory transfers. A command carries a 16-bit register bitmap, a direction (push to memory or pop from memory), the current stack pointer value and a writeback flag. The block works through the set bits of the bitmap from lowest to highest index. For each set bit it makes one memory request and drives the matching register index to the register file.

Addressing follows a full-descending stack. The lowest listed register always sits at the lowest address, and consecutive listed registers occupy consecutive 4-byte words. A push therefore starts 4·N bytes below the pointer, where N is the number of listed registers, and leaves that address as the new pointer. A pop starts at the pointer and leaves it 4·N bytes higher. When a pop includes register 15, the word loaded for that register is offered as a branch target, so the exit sequence of a subroutine becomes a return.

The memory side uses a plain request/ready handshake. Register-file reads are combinational. Register-file writes for a pop are issued in the same cycle the memory accepts the transfer.

Top module: `stack_xfer_seq`

## Requirements
- R1: `cmd_ready` is 1 exactly while no command is in progress. A command is taken only on a cycle with `cmd_valid` and `cmd_ready` both 1. A `cmd_valid` raised while busy has no effect.
- R2: For a push (`cmd_load`=0), the first transfer address is `cmd_base - 4*N`. Every transfer has `mem_we`=1 and `rf_rd_en`=1, and `mem_wdata` equals `rf_rd_data` for the register at `xfer_idx`.
- R3: For a pop (`cmd_load`=1), the first transfer address is `cmd_base`. Every transfer has `mem_we`=0. In the cycle the memory accepts a transfer, `rf_wr_en`=1 and `rf_wr_data` equals `mem_rdata`.
- R4: Listed registers are transferred in ascending index order, one per accepted handshake (`mem_req` and `mem_ready` both 1). Each accepted transfer advances the address by 4, and clear bitmap bits cost no cycle.
- R5: While `mem_req`=1 and `mem_ready`=0, the next cycle keeps `mem_req`=1 with the same `mem_addr` and `xfer_idx`.
- R6: `done` is 1 for one cycle, the cycle after the last accepted transfer. If writeback was requested and the list is non-empty, `base_wr_en`=1 in that cycle, with `base_wr_val` = `cmd_base - 4*N` for a push or `cmd_base + 4*N` for a pop.
- R7: With `cmd_wb`=0, `base_wr_en` stays 0 for that command.
- R8: An empty bitmap raises `done` the cycle after acceptance, with no `mem_req` and `base_wr_en`=0.
- R9: When a pop lists register 15 (bit 15 of `cmd_list`), `branch_valid`=1 together with `done`, and `branch_target` holds the word loaded for index 15. Otherwise `branch_valid`=0.
- R10: After reset `cmd_ready`=1, and `mem_req`, `done`, `base_wr_en` and `branch_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_load | input | 1 | 1 = pop (memory to registers), 0 = push |
| cmd_list | input | 16 | Register bitmap, bit i selects register i |
| cmd_base | input | 32 | Stack pointer value |
| cmd_wb | input | 1 | Write updated pointer back |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write to memory |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Store data |
| mem_ready | input | 1 | Memory accepts the current request |
| mem_rdata | input | 32 | Load data, valid with mem_ready |
| xfer_idx | output | 4 | Register index of the current transfer |
| rf_rd_en | output | 1 | Register-file read request (push) |
| rf_rd_data | input | 32 | Register-file read data for xfer_idx |
| rf_wr_en | output | 1 | Register-file write request (pop) |
| rf_wr_data | output | 32 | Register-file write data |
| done | output | 1 | One-cycle completion pulse |
| base_wr_en | output | 1 | Write base_wr_val to the stack pointer |
| base_wr_val | output | 32 | Updated stack pointer |
| branch_valid | output | 1 | Pop loaded register 15 |
| branch_target | output | 32 | Loaded return address |

## Verification
The first request is due one cycle after the command is taken. Each transfer's address, index and data are checked in the cycle of its accepted handshake. Register-file write data for a pop is due in that same cycle. `done`, the pointer writeback and the branch outputs are due one cycle after the last handshake, or one cycle after acceptance for an empty list. Inputs change just after the rising edge and outputs are sampled on the falling edge, so each scoreboard comparison sees the values for exactly the cycle being checked.

// File: rtl/stack_xfer_seq.sv
module stack_xfer_seq #(
  parameter int DW   = 32,
  parameter int NREG = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic            cmd_load,
  input  logic [NREG-1:0] cmd_list,
  input  logic [DW-1:0]   cmd_base,
  input  logic            cmd_wb,
  output logic            mem_req,
  output logic            mem_we,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ready,
  input  logic [DW-1:0]   mem_rdata,
  output logic [$clog2(NREG)-1:0] xfer_idx,
  output logic            rf_rd_en,
  input  logic [DW-1:0]   rf_rd_data,
  output logic            rf_wr_en,
  output logic [DW-1:0]   rf_wr_data,
  output logic            done,
  output logic            base_wr_en,
  output logic [DW-1:0]   base_wr_val,
  output logic            branch_valid,
  output logic [DW-1:0]   branch_target
);
  localparam int IDXW  = $clog2(NREG);
  localparam int WORDB = DW / 8;
  localparam logic [IDXW-1:0] PC_IDX = IDXW'(NREG - 1);

  logic            busy, ld_q, wb_q, done_q, pc_hit_q;
  logic [NREG-1:0] rem_q;
  logic [DW-1:0]   addr_q, fin_q, pc_q;
  logic [IDXW-1:0] cur;
  logic [DW-1:0]   span;
  logic            last, hs;

  always_comb begin
    cur = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (rem_q[i]) cur = IDXW'(i);
  end

  always_comb begin
    span = '0;
    for (int i = 0; i < NREG; i++)
      if (cmd_list[i]) span = span + DW'(WORDB);
  end

  assign last = ((rem_q & (rem_q - NREG'(1))) == '0);
  assign hs   = busy && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done_q   <= 1'b0;
      ld_q     <= 1'b0;
      wb_q     <= 1'b0;
      pc_hit_q <= 1'b0;
      rem_q    <= '0;
      addr_q   <= '0;
      fin_q    <= '0;
      pc_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy && cmd_valid) begin
        rem_q    <= cmd_list;
        ld_q     <= cmd_load;
        wb_q     <= cmd_wb && (cmd_list != '0);
        addr_q   <= cmd_load ? cmd_base : cmd_base - span;
        fin_q    <= cmd_load ? cmd_base + span : cmd_base - span;
        pc_hit_q <= 1'b0;
        busy     <= (cmd_list != '0);
        done_q   <= (cmd_list == '0);
      end else if (hs) begin
        rem_q  <= rem_q & ~(NREG'(1) << cur);
        addr_q <= addr_q + DW'(WORDB);
        if (ld_q && cur == PC_IDX) begin
          pc_q     <= mem_rdata;
          pc_hit_q <= 1'b1;
        end
        if (last) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign cmd_ready     = !busy;
  assign mem_req       = busy;
  assign mem_we        = busy && !ld_q;
  assign mem_addr      = addr_q;
  assign mem_wdata     = rf_rd_data;
  assign xfer_idx      = cur;
  assign rf_rd_en      = busy && !ld_q;
  assign rf_wr_en      = hs && ld_q;
  assign rf_wr_data    = mem_rdata;
  assign done          = done_q;
  assign base_wr_en    = done_q && wb_q;
  assign base_wr_val   = fin_q;
  assign branch_valid  = done_q && pc_hit_q;
  assign branch_target = pc_q;

  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && !last) |=> (mem_req && mem_addr == $past(mem_addr) + DW'(WORDB)));

  a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && !last) |=> (xfer_idx > $past(xfer_idx)));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(xfer_idx)));

  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && last) |=> (done && !mem_req));

  a_r8_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_list == '0) |=> (done && !mem_req && !base_wr_en));

  a_r9_branch_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    branch_valid |-> done);
endmodule

// File: tb/stack_xfer_seq_tb_top.sv
module stack_xfer_seq_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_load = 1'b0, cmd_wb = 1'b0;
  logic [15:0] cmd_list = '0;
  logic [31:0] cmd_base = '0;
  logic        cmd_ready, mem_req, mem_we, mem_ready = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rd_data, rf_wr_data;
  logic [3:0]  xfer_idx;
  logic        rf_rd_en, rf_wr_en, done, base_wr_en, branch_valid;
  logic [31:0] base_wr_val, branch_target;

  always #10 clk = ~clk;

  stack_xfer_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_load(cmd_load), .cmd_list(cmd_list), .cmd_base(cmd_base), .cmd_wb(cmd_wb),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .xfer_idx(xfer_idx),
    .rf_rd_en(rf_rd_en), .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en),
    .rf_wr_data(rf_wr_data), .done(done), .base_wr_en(base_wr_en),
    .base_wr_val(base_wr_val), .branch_valid(branch_valid), .branch_target(branch_target)
  );

  logic [31:0] mem [64];
  logic [31:0] rf  [16];
  assign mem_rdata  = mem[mem_addr[7:2]];
  assign rf_rd_data = rf[xfer_idx];

  always @(posedge clk) begin
    if (mem_req && mem_ready && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    if (rf_wr_en) rf[xfer_idx] <= rf_wr_data;
  end

  logic       rnd_mode = 1'b0;
  logic [7:0] lfsr = 8'h5A;
  always begin
    @(posedge clk);
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready = rnd_mode ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [3:0]  idx;
    logic [31:0] data;
  } xfer_t;
  typedef struct {
    logic        bw;
    logic [31:0] bv;
    logic        br;
    logic [31:0] bt;
    string       tag;
  } end_t;

  xfer_t exp_x[$];
  end_t  exp_d[$];
  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", msg, act, exp);
    end
  endtask

  task automatic issue(input logic ld, input logic [15:0] list, input logic [31:0] base, input logic wb, input string tag);
    int n;
    logic [31:0] start, a;
    xfer_t x;
    end_t d;
    @(negedge clk);
    while (!cmd_ready || exp_x.size() != 0 || exp_d.size() != 0) @(negedge clk);
    n = $countones(list);
    start = ld ? base : base - 32'(4 * n);
    a = start;
    d.br = 1'b0;
    d.bt = '0;
    for (int i = 0; i < 16; i++) begin
      if (list[i]) begin
        x.we = !ld; x.addr = a; x.idx = 4'(i);
        x.data = ld ? mem[a[7:2]] : rf[i];
        if (ld && i == 15) begin d.br = 1'b1; d.bt = x.data; end
        exp_x.push_back(x);
        a = a + 32'd4;
      end
    end
    d.bw  = wb && (n != 0);
    d.bv  = ld ? base + 32'(4 * n) : base - 32'(4 * n);
    d.tag = tag;
    exp_d.push_back(d);
    cmd_valid = 1'b1; cmd_load = ld; cmd_list = list; cmd_base = base; cmd_wb = wb;
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!cmd_ready || exp_x.size() != 0 || exp_d.size() != 0) @(negedge clk);
  endtask

  logic        stall_prev = 1'b0;
  logic [31:0] addr_prev;
  logic [3:0]  idx_prev;

  always @(negedge clk) if (rst_n) begin
    if (stall_prev)
      chk(mem_req && mem_addr == addr_prev && xfer_idx == idx_prev,
          "R5 request held under stall", mem_addr, addr_prev);
    stall_prev = mem_req && !mem_ready;
    addr_prev  = mem_addr;
    idx_prev   = xfer_idx;
    if (mem_req) chk(!cmd_ready, "R1 cmd_ready low while busy", 32'(cmd_ready), 32'd0);
    if (mem_req && mem_ready) begin
      if (exp_x.size() == 0) begin
        chk(1'b0, "R4 unexpected transfer", mem_addr, 32'hx);
      end else begin
        xfer_t e;
        e = exp_x.pop_front();
        chk(mem_addr == e.addr && xfer_idx == e.idx && mem_we == e.we,
            "R4 address/index/direction", {mem_addr[23:0], 3'b0, mem_we, xfer_idx},
            {e.addr[23:0], 3'b0, e.we, e.idx});
        if (e.we)
          chk(rf_rd_en && !rf_wr_en && mem_wdata == e.data, "R2 push data", mem_wdata, e.data);
        else
          chk(rf_wr_en && !rf_rd_en && rf_wr_data == e.data, "R3 pop data", rf_wr_data, e.data);
      end
    end
    if (done) begin
      if (exp_d.size() == 0) begin
        chk(1'b0, "R6 unexpected done", 32'd1, 32'd0);
      end else begin
        end_t e;
        e = exp_d.pop_front();
        chk(exp_x.size() == 0, {"R6 done after last transfer ", e.tag}, 32'(exp_x.size()), 32'd0);
        chk(base_wr_en == e.bw && (!e.bw || base_wr_val == e.bv),
            {"R6 R7 pointer writeback ", e.tag}, base_wr_en ? base_wr_val : 32'hFFFF_FFFF,
            e.bw ? e.bv : 32'hFFFF_FFFF);
        chk(branch_valid == e.br && (!e.br || branch_target == e.bt),
            {"R9 branch ", e.tag}, branch_valid ? branch_target : 32'hFFFF_FFFF,
            e.br ? e.bt : 32'hFFFF_FFFF);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 32'hA000_0000 + 32'(i * 32'h111);
    for (int i = 0; i < 64; i++) mem[i] = 32'hC0DE_0000 + 32'(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cmd_ready && !mem_req && !done && !base_wr_en && !branch_valid,
        "R10 reset state", {27'd0, cmd_ready, mem_req, done, base_wr_en, branch_valid}, 32'h10);
    #1 rst_n = 1'b1;

    issue(1'b0, 16'h407C, 32'h0000_0100, 1'b1, "R2 entry push");
    issue(1'b1, 16'h807C, 32'h0000_00E8, 1'b1, "R3 R9 exit pop returns");
    wait_idle();
    chk(rf[2] == 32'hA000_0222 && rf[6] == 32'hA000_0666, "R3 restored registers", rf[6], 32'hA000_0666);

    rnd_mode = 1'b1;
    issue(1'b0, 16'hFFFF, 32'h0000_0100, 1'b1, "R4 full push random ready");
    issue(1'b1, 16'h0001, 32'h0000_00C0, 1'b0, "R7 single pop no writeback");
    issue(1'b0, 16'h0000, 32'h0000_0080, 1'b1, "R8 empty push");
    issue(1'b1, 16'h0000, 32'h0000_0080, 1'b1, "R8 empty pop");
    issue(1'b1, 16'h8001, 32'h0000_0040, 1'b1, "R9 sparse pop");
    issue(1'b0, 16'h2A54, 32'h0000_0080, 1'b0, "R4 sparse push");

    issue(1'b0, 16'h0FF0, 32'h0000_0100, 1'b1, "R1 busy ignore");
    @(negedge clk);
    cmd_valid = 1'b1; cmd_load = 1'b1; cmd_list = 16'h0003; cmd_base = 32'h10; cmd_wb = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(!cmd_ready, "R1 new command while busy", 32'(cmd_ready), 32'd0);
    end
    cmd_valid = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
    chk(exp_x.size() == 0 && exp_d.size() == 0 && !mem_req, "R1 no extra command taken",
        32'(mem_req), 32'd0);

    rnd_mode = 1'b0;
    issue(1'b1, 16'hFFFF, 32'h0000_00C0, 1'b1, "R3 full pop");
    wait_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule